// File: doc/BRIEF.md
# Symmetric Up-Down PWM Generator with Shadowed Period and Compare

The block produces a centre-aligned PWM waveform from a time-base counter that climbs from zero to the active period and then falls back to zero. Period and duty compare values are written into shadow registers through a small register write port. Each shadow value reaches its active register only at selected counter events. Because of this, software can stage a new value at any time without tearing the waveform in the current half-cycle.

The compare value can be moved into the active register at the counter trough, at the counter peak, or at both. Using both gives two independent duty updates per PWM cycle. The period only moves at the trough, on an external sync pulse, or at both, so it changes at most once per cycle unless sync is used. A high-resolution flag claims the peak opportunity for other use, which leaves compare loading at the trough only.

A combined event pulse, which can be masked to the trough and/or the peak, gives the interrupt timing. A direction output reports whether the counter is climbing.

Top module: `updown_pwm`

## Requirements
- R1: After reset the counter is zero and counting up. The shadow and active period and compare values are zero, and the configuration is zero. So `pwm_out`=0, `dir_up`=1 and `evt_pulse`=0, and with a zero period the counter stays at zero.
- R2: With active period P>0 the counter runs 0,1,…,P,P-1,…,1,0 and repeats, so one cycle is 2·P clocks and each endpoint is held one clock. `dir_up` is 1 while the counter shows 0…P and 0 while it shows P-1…1.
- R3: `pwm_out` is 1 when the active compare C is nonzero and either C ≥ active period or counter < C, and 0 otherwise. So C=0 gives 0% and C ≥ P gives 100%.
- R4: Write address 0 targets the period shadow, address 1 the compare shadow and address 2 the configuration. Address 3 is ignored. Configuration bits [1:0] set the compare load mode: 00 = at zero, 01 = at peak, 10 = at zero and at peak, 11 = at zero.
- R5: In mode 10, a compare value written before the zero event governs the rising half. A value written after zero and before the peak governs the falling half of the same cycle.
- R6: A period write lands in the shadow. With configuration bits [3:2] = 00 it reaches the active period only at counter zero, so the cycle in progress keeps its length.
- R7: Configuration bits [3:2] = 01 load the period at zero and also in any clock where `sync_in` is high. 10 loads it only on `sync_in`. 11 behaves as 00.
- R8: With configuration bit 6 (high-resolution flag) set, the compare loads only at counter zero, whatever the load mode.
- R9: `evt_pulse` is high at counter zero when configuration bit 4 is set and at the peak when bit 5 is set. The peak pulse coincides with the last clock of `dir_up`=1.
- R10: A shadow write in the same clock as a load event is captured first, and the written value is the one transferred to the active register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | W | Write data |
| sync_in | input | 1 | External period-load sync pulse |
| pwm_out | output | 1 | PWM waveform |
| dir_up | output | 1 | Counter direction, 1 = up |
| evt_pulse | output | 1 | Zero/peak event pulse |

## Verification
Several behaviours are checked on every cycle by assertions: the counter step and its reversals at the endpoints, that the active period holds away from zero unless sync is high, and that the compare holds away from zero in zero-only mode or with the high-resolution flag. They also check that the event pulse only appears at an endpoint and that a zero compare never drives the output high. Other behaviours depend on when a write lands relative to the counter, and only the bench's scenarios can show them: the two duty updates in one cycle, peak-only loading, a write colliding with a load, and mid-cycle sync loads of the period. The bench checks these by counting high samples in each half-cycle and by measuring the spacing of zero events.

// File: rtl/updown_pwm.sv
`timescale 1ns/1ps
module updown_pwm #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  input  logic         sync_in,
  output logic         pwm_out,
  output logic         dir_up,
  output logic         evt_pulse
);

  localparam logic [1:0] LD_PEAK = 2'b01;
  localparam logic [1:0] LD_BOTH = 2'b10;
  localparam logic [1:0] PS_ZSYNC = 2'b01;
  localparam logic [1:0] PS_SYNC  = 2'b10;
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt, prd_sh, prd_act, cmp_sh, cmp_act;
  logic [1:0]   ld_mode, prd_sel, evt_sel;
  logic         hr_flag, up;

  wire wr_prd = wr_en && (wr_addr == 2'd0);
  wire wr_cmp = wr_en && (wr_addr == 2'd1);
  wire wr_cfg = wr_en && (wr_addr == 2'd2);

  wire [W-1:0] prd_sh_nx = wr_prd ? wr_data : prd_sh;
  wire [W-1:0] cmp_sh_nx = wr_cmp ? wr_data : cmp_sh;

  wire at_zero = (cnt == '0);
  wire at_peak = up && (prd_act != '0) && (cnt >= prd_act);

  wire cmp_zero_ok = hr_flag || (ld_mode != LD_PEAK);
  wire cmp_peak_ok = !hr_flag && ((ld_mode == LD_PEAK) || (ld_mode == LD_BOTH));
  wire ld_cmp = (at_zero && cmp_zero_ok) || (at_peak && cmp_peak_ok);

  wire sync_ok = (prd_sel == PS_ZSYNC) || (prd_sel == PS_SYNC);
  wire ld_prd = (at_zero && (prd_sel != PS_SYNC)) || (sync_in && sync_ok);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prd_sh  <= '0;
      cmp_sh  <= '0;
      prd_act <= '0;
      cmp_act <= '0;
      ld_mode <= '0;
      prd_sel <= '0;
      evt_sel <= '0;
      hr_flag <= 1'b0;
    end else begin
      prd_sh <= prd_sh_nx;
      cmp_sh <= cmp_sh_nx;
      if (ld_prd) prd_act <= prd_sh_nx;
      if (ld_cmp) cmp_act <= cmp_sh_nx;
      if (wr_cfg) begin
        ld_mode <= wr_data[1:0];
        prd_sel <= wr_data[3:2];
        evt_sel <= wr_data[5:4];
        hr_flag <= wr_data[6];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      up  <= 1'b1;
    end else if (prd_act == '0) begin
      cnt <= '0;
      up  <= 1'b1;
    end else if (up) begin
      if (cnt >= prd_act) begin
        cnt <= cnt - ONE;
        up  <= (cnt == ONE);
      end else begin
        cnt <= cnt + ONE;
      end
    end else if (cnt <= ONE) begin
      cnt <= '0;
      up  <= 1'b1;
    end else begin
      cnt <= cnt - ONE;
    end
  end

  assign dir_up    = up;
  assign pwm_out   = (cmp_act != '0) && ((cmp_act >= prd_act) || (cnt < cmp_act));
  assign evt_pulse = (evt_sel[0] && at_zero) || (evt_sel[1] && at_peak);

  AST_UP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (up && cnt < prd_act) |=> (cnt == $past(cnt) + ONE)); // R2
  AST_PEAK_TURN: assert property (@(posedge clk) disable iff (!rst_n)
    (at_peak && prd_act > ONE && cnt == prd_act) |=> (!dir_up && cnt == $past(prd_act) - ONE)); // R2
  AST_TROUGH_TURN: assert property (@(posedge clk) disable iff (!rst_n)
    (!up && cnt == ONE) |=> (dir_up && cnt == '0)); // R2
  AST_ZERO_DUTY: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_act == '0) |-> !pwm_out); // R3
  AST_ZERO_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_mode == 2'b00 && cnt != '0) |=> $stable(cmp_act)); // R4
  AST_PRD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0 && !sync_in) |=> $stable(prd_act)); // R6
  AST_HR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (hr_flag && cnt != '0) |=> $stable(cmp_act)); // R8
  AST_EVT_ENDPOINT: assert property (@(posedge clk) disable iff (!rst_n)
    evt_pulse |-> (cnt == '0 || (dir_up && cnt >= prd_act))); // R9

endmodule

// File: tb/updown_pwm_tb.sv
`timescale 1ns/1ps
module updown_pwm_tb;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic sync_in = 1'b0;
  logic pwm_out, dir_up, evt_pulse;

  int n_chk = 0;
  int n_bad = 0;
  int up_hi, dn_hi, k0_hi, len;

  always #4 clk = ~clk;

  updown_pwm #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .sync_in(sync_in), .pwm_out(pwm_out),
    .dir_up(dir_up), .evt_pulse(evt_pulse)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] cfgv(input int mode, input int psel, input int esel, input int hr);
    return W'((hr << 6) | (esel << 4) | (psel << 2) | mode);
  endfunction

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'(a); wr_data = W'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_evt();
    int g = 0;
    @(negedge clk);
    while (!evt_pulse && g < 2000) begin
      @(negedge clk);
      g++;
    end
    if (g >= 2000) chk("event wait timeout", 0, 1);
  endtask

  task automatic drive(input int k, input int wr_k, input int wr_a, input int wr_v, input int sy_k);
    if (k == wr_k) begin
      wr_en = 1'b1; wr_addr = 2'(wr_a); wr_data = W'(wr_v);
    end
    if (k == sy_k) sync_in = 1'b1;
  endtask

  // Aligns to a zero event (zero-only event select) and counts high samples.
  task automatic run_cycle(input int p, input int wr_k, input int wr_v);
    up_hi = 0; dn_hi = 0;
    wait_evt();
    k0_hi = int'(pwm_out);
    drive(0, wr_k, 1, wr_v, -1);
    for (int k = 1; k < 2 * p; k++) begin
      @(negedge clk);
      wr_en = 1'b0; sync_in = 1'b0;
      if (pwm_out) begin
        if (k <= p) up_hi++; else dn_hi++;
      end
      drive(k, wr_k, 1, wr_v, -1);
    end
  endtask

  task automatic period_len(input int wr_k, input int wr_v, input int sy_k);
    int g = 0;
    len = 0;
    wait_evt();
    drive(0, wr_k, 0, wr_v, sy_k);
    do begin
      @(negedge clk);
      wr_en = 1'b0; sync_in = 1'b0;
      len++; g++;
      if (!evt_pulse) drive(len, wr_k, 0, wr_v, sy_k);
    end while (!evt_pulse && g < 2000);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 pwm after reset", int'(pwm_out), 0);
    chk("R1 dir after reset", int'(dir_up), 1);
    chk("R1 evt after reset", int'(evt_pulse), 0);
    repeat (5) @(negedge clk);
    chk("R1 counter held at zero (dir)", int'(dir_up), 1);
    chk("R1 pwm still low", int'(pwm_out), 0);
  endtask

  task automatic t_basic();
    int ups = 0;
    wr(0, 8);
    wr(1, 3);
    wr(2, cfgv(0, 0, 1, 0));
    run_cycle(8, -1, 0);
    run_cycle(8, -1, 0);
    chk("R3 rising-half highs C=3", up_hi, 2);
    chk("R3 falling-half highs C=3", dn_hi, 2);
    wait_evt();
    ups = 1;
    for (int k = 1; k < 16; k++) begin
      @(negedge clk);
      if (dir_up) ups++;
      if (k == 8) chk("R2 direction still up at peak", int'(dir_up), 1);
    end
    chk("R2 up samples per cycle", ups, 9);
    period_len(-1, 0, -1);
    chk("R2 cycle length 2P", len, 16);
  endtask

  task automatic t_either();
    wr(2, cfgv(2, 0, 1, 0));
    wr(1, 6);
    run_cycle(8, -1, 0);
    run_cycle(8, 2, 2);
    chk("R5 rising half uses value staged before zero", up_hi, 5);
    chk("R5 falling half uses value written after zero", dn_hi, 1);
    run_cycle(8, -1, 0);
    chk("R5 next cycle rising", up_hi, 1);
  endtask

  task automatic t_zero_mode();
    wr(2, cfgv(0, 0, 1, 0));
    wr(1, 6);
    run_cycle(8, -1, 0);
    run_cycle(8, 2, 2);
    chk("R4 zero mode rising", up_hi, 5);
    chk("R4 zero mode ignores peak", dn_hi, 5);
    run_cycle(8, -1, 0);
    chk("R4 zero mode loads next cycle", up_hi, 1);
  endtask

  task automatic t_peak_mode();
    wr(2, cfgv(1, 0, 1, 0));
    wr(1, 6);
    run_cycle(8, -1, 0);
    run_cycle(8, 2, 2);
    chk("R4 peak mode rising keeps old", up_hi, 5);
    chk("R4 peak mode falling loads", dn_hi, 1);
  endtask

  task automatic t_hr();
    wr(2, cfgv(2, 0, 1, 1));
    wr(1, 6);
    run_cycle(8, -1, 0);
    run_cycle(8, 2, 2);
    chk("R8 hr rising", up_hi, 5);
    chk("R8 hr blocks peak load", dn_hi, 5);
    wr(2, cfgv(0, 0, 1, 0));
  endtask

  task automatic t_collide();
    wr(1, 6);
    run_cycle(8, -1, 0);
    run_cycle(8, 0, 2);
    chk("R10 write at zero is loaded same edge", up_hi, 1);
    chk("R10 falling half", dn_hi, 1);
  endtask

  task automatic t_extremes();
    wr(1, 0);
    run_cycle(8, -1, 0);
    run_cycle(8, -1, 0);
    chk("R3 zero compare low all cycle", up_hi + dn_hi + k0_hi, 0);
    wr(1, 8);
    run_cycle(8, -1, 0);
    run_cycle(8, -1, 0);
    chk("R3 compare=P full high", up_hi + dn_hi + k0_hi, 16);
    wr(1, 300);
    run_cycle(8, -1, 0);
    run_cycle(8, -1, 0);
    chk("R3 compare>P full high", up_hi + dn_hi + k0_hi, 16);
    wr(3, 2);
    run_cycle(8, -1, 0);
    run_cycle(8, -1, 0);
    chk("R4 address 3 ignored", up_hi + dn_hi + k0_hi, 16);
  endtask

  task automatic t_events();
    int c;
    wr(2, cfgv(0, 0, 2, 0));
    wait_evt();
    chk("R9 peak pulse on last up clock", int'(dir_up), 1);
    @(negedge clk);
    chk("R9 direction falls after peak", int'(dir_up), 0);
    c = 0;
    for (int k = 0; k < 16; k++) begin @(negedge clk); if (evt_pulse) c++; end
    chk("R9 peak-only pulses per cycle", c, 1);
    wr(2, cfgv(0, 0, 3, 0));
    c = 0;
    for (int k = 0; k < 16; k++) begin @(negedge clk); if (evt_pulse) c++; end
    chk("R9 both pulses per cycle", c, 2);
    wr(2, cfgv(0, 0, 0, 0));
    c = 0;
    for (int k = 0; k < 16; k++) begin @(negedge clk); if (evt_pulse) c++; end
    chk("R9 no pulses when masked", c, 0);
    wr(2, cfgv(0, 0, 1, 0));
  endtask

  task automatic t_period();
    period_len(3, 5, -1);
    chk("R6 current cycle keeps length", len, 16);
    period_len(-1, 0, -1);
    chk("R6 next cycle new length", len, 10);
    wr(2, cfgv(0, 2, 1, 0));
    wr(0, 8);
    period_len(-1, 0, -1);
    chk("R7 sync-only ignores zero", len, 10);
    period_len(-1, 0, 0);
    chk("R7 sync-only loads on sync", len, 16);
    wr(2, cfgv(0, 1, 1, 0));
    wr(0, 6);
    period_len(-1, 0, -1);
    chk("R7 zero-or-sync loads at zero", len, 12);
    period_len(1, 10, 4);
    chk("R7 zero-or-sync loads mid-cycle", len, 20);
    wr(2, cfgv(0, 0, 1, 0));
    wr(0, 8);
    period_len(-1, 0, -1);
    chk("R6 restore period", len, 16);
  endtask

  initial begin
    #(8 * 200000);
    chk("watchdog expired", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_either();
    t_zero_mode();
    t_peak_mode();
    t_hr();
    t_collide();
    t_extremes();
    t_events();
    t_period();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule